// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block sits in front of a synchronous memory array and turns an externally supplied word address into the address sequence of a four-beat burst. An address is captured when a load strobe is seen on a rising clock edge. Two strobes exist: a processor-side one and a controller-side one. The processor-side strobe is masked by the primary chip enable. The controller-side strobe is not masked; instead it deselects the block when the primary chip enable is low. After a load, the two low address bits step through the burst each time the advance input is high. The upper bits stay as they were loaded.

The burst order comes from a select pin. When the pin is low, the order is linear: the low bits count up modulo four from the loaded value. When the pin is high, the order is interleaved: each beat address is the loaded bits XOR the beat number. On the fourth advance the address comes back to the loaded start. A new address may be loaded on every cycle, so the burst feature is optional.

Every output is registered. The effect of a command seen at one rising edge is visible on the outputs right after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, and after the first edge that samples it, `word_addr` is 0, `burst_on` is 0 and `selected` is 0.
- R2: A processor strobe (`load_cpu`=1) with `en_main`=1, `en_aux0`=1 and `en_aux1`=1 loads `addr_in` into `word_addr` at the edge and sets `burst_on`=1 and `selected`=1.
- R3: A processor strobe with `en_main`=0 and no controller strobe is ignored. All three outputs keep their values.
- R4: A controller strobe (`load_ctl`=1) loads the address and sets both flags when all three enables are 1. If any enable is 0, it deselects: `selected`=0 and `burst_on`=0, and `word_addr` is unchanged. The same deselect happens for an accepted processor strobe when either auxiliary enable is 0.
- R5: The auxiliary enables have no effect in a cycle with no load strobe.
- R6: With `order_sel`=0, advance n after a load sets `word_addr[1:0]` to (start + n) mod 4.
- R7: With `order_sel`=1, advance n sets `word_addr[1:0]` to start XOR (n mod 4).
- R8: The fourth advance returns the low bits to the loaded start. `word_addr[AW-1:2]` never changes during a burst.
- R9: In a cycle with no strobe and `advance`=0, `word_addr` holds.
- R10: `advance` has no effect while `burst_on`=0.
- R11: If both strobes are high and `en_main`=1, the processor strobe acts. If both are high and `en_main`=0, the controller strobe acts and deselects.
- R12: Loads on consecutive cycles each take effect at their own edge, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | AW | External word address |
| load_cpu | input | 1 | Processor-side load strobe, active high |
| load_ctl | input | 1 | Controller-side load strobe, active high |
| advance | input | 1 | Burst advance enable |
| en_main | input | 1 | Primary chip enable, active high |
| en_aux0 | input | 1 | Auxiliary chip enable, sampled only with a strobe |
| en_aux1 | input | 1 | Auxiliary chip enable, sampled only with a strobe |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| word_addr | output | AW | Current word address |
| burst_on | output | 1 | A burst has been started and not deselected |
| selected | output | 1 | The last load strobe selected the block |

## Verification
The checker verifies the following on every cycle:
- an accepted load shows up at the next edge;
- a masked processor strobe and an advance with no active burst leave the outputs frozen;
- a failed enable check clears both flags;
- `burst_on` never stands without `selected`;
- advances never disturb the upper address bits.

Only the bench scenarios can show the exact beat sequences in both orders for all four start values, the wrap back to the start, and the priority between the two strobes.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_DESEL = 2'd2,
        OP_STEP  = 2'd3
    } op_e;

    typedef enum logic {
        ORD_LIN = 1'b0,
        ORD_ILV = 1'b1
    } ord_e;

    function automatic logic [BEAT_W-1:0] beat_bits(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] n,
        input ord_e              ord
    );
        if (ord == ORD_ILV) begin
            return start ^ n;
        end
        return start + n;
    endfunction

endpackage

// File: rtl/bag_strobe_arb.sv
module bag_strobe_arb
    import bag_pkg::*;
(
    input  logic load_cpu,
    input  logic load_ctl,
    input  logic advance,
    input  logic en_main,
    input  logic en_aux0,
    input  logic en_aux1,
    input  logic active,
    output op_e  op
);
    logic aux_ok;
    logic cpu_seen;

    assign aux_ok   = en_aux0 & en_aux1;
    assign cpu_seen = load_cpu & en_main;

    always_comb begin
        if (cpu_seen) begin
            op = aux_ok ? OP_LOAD : OP_DESEL;
        end else if (load_ctl) begin
            op = (en_main & aux_ok) ? OP_LOAD : OP_DESEL;
        end else if (advance & active) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
    import bag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    output logic [BEAT_W-1:0] cnt,
    output logic [BEAT_W-1:0] cnt_nxt
);
    assign cnt_nxt = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                OP_LOAD, OP_DESEL: cnt <= '0;
                OP_STEP:           cnt <= cnt_nxt;
                default:           cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/bag_addr_hold.sv
module bag_addr_hold
    import bag_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  ord_e              ord,
    input  logic [AW-1:0]     addr_in,
    input  logic [BEAT_W-1:0] cnt_nxt,
    output logic [AW-1:0]     addr_q
);
    localparam int HI_W = AW - BEAT_W;

    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] lo_q;
    logic [BEAT_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            lo_q    <= '0;
            start_q <= '0;
        end else begin
            case (op)
                OP_LOAD: begin
                    hi_q    <= addr_in[AW-1:BEAT_W];
                    lo_q    <= addr_in[BEAT_W-1:0];
                    start_q <= addr_in[BEAT_W-1:0];
                end
                OP_STEP: lo_q <= beat_bits(start_q, cnt_nxt, ord);
                default: ;
            endcase
        end
    end

    assign addr_q = {hi_q, lo_q};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_in,
    input  logic          load_cpu,
    input  logic          load_ctl,
    input  logic          advance,
    input  logic          en_main,
    input  logic          en_aux0,
    input  logic          en_aux1,
    input  logic          order_sel,
    output logic [AW-1:0] word_addr,
    output logic          burst_on,
    output logic          selected
);
    op_e               op;
    logic              active_q;
    logic              sel_q;
    logic [BEAT_W-1:0] cnt;
    logic [BEAT_W-1:0] cnt_nxt;
    ord_e              ord;

    assign ord = ord_e'(order_sel);

    bag_strobe_arb u_arb (
        .load_cpu (load_cpu),
        .load_ctl (load_ctl),
        .advance  (advance),
        .en_main  (en_main),
        .en_aux0  (en_aux0),
        .en_aux1  (en_aux1),
        .active   (active_q),
        .op       (op)
    );

    bag_beat_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    bag_addr_hold #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ord     (ord),
        .addr_in (addr_in),
        .cnt_nxt (cnt_nxt),
        .addr_q  (word_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sel_q    <= 1'b0;
        end else if (op == OP_LOAD) begin
            active_q <= 1'b1;
            sel_q    <= 1'b1;
        end else if (op == OP_DESEL) begin
            active_q <= 1'b0;
            sel_q    <= 1'b0;
        end
    end

    assign burst_on = active_q;
    assign selected = sel_q;
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr_in,
    input logic          load_cpu,
    input logic          load_ctl,
    input logic          advance,
    input logic          en_main,
    input logic          en_aux0,
    input logic          en_aux1,
    input logic [AW-1:0] word_addr,
    input logic          burst_on,
    input logic          selected
);
    logic take;
    logic drop;
    logic quiet;

    assign take  = (load_cpu & en_main & en_aux0 & en_aux1)
                 | (load_ctl & en_main & en_aux0 & en_aux1);
    assign drop  = (load_cpu & en_main & ~(en_aux0 & en_aux1))
                 | (load_ctl & ~(load_cpu & en_main) & ~(en_main & en_aux0 & en_aux1));
    assign quiet = ~load_ctl & ~(load_cpu & en_main);

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> (word_addr == $past(addr_in)) && burst_on && selected);

    assert_masked_R3: assert property (@(posedge clk) disable iff (rst)
        (load_cpu & ~en_main & ~load_ctl) |=> $stable(word_addr) && $stable(burst_on) && $stable(selected));

    assert_desel_R4: assert property (@(posedge clk) disable iff (rst)
        drop |=> !selected && !burst_on && $stable(word_addr));

    assert_idle_adv_R10: assert property (@(posedge clk) disable iff (rst)
        (quiet & ~burst_on) |=> $stable(word_addr) && !burst_on);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (quiet & ~advance) |=> $stable(word_addr));

    assert_upper_R8: assert property (@(posedge clk) disable iff (rst)
        quiet |=> $stable(word_addr[AW-1:2]));

    assert_flags_R4: assert property (@(posedge clk) disable iff (rst)
        burst_on |-> selected);
endmodule

bind burst_addr_gen bag_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_in   (addr_in),
    .load_cpu  (load_cpu),
    .load_ctl  (load_ctl),
    .advance   (advance),
    .en_main   (en_main),
    .en_aux0   (en_aux0),
    .en_aux1   (en_aux1),
    .word_addr (word_addr),
    .burst_on  (burst_on),
    .selected  (selected)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int AW = 20;
    localparam time CLK_T = 10ns;

    typedef struct {
        logic [AW-1:0] a;
        logic          act;
        logic          sel;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          load_cpu = 1'b0, load_ctl = 1'b0, advance = 1'b0;
    logic          en_main = 1'b0, en_aux0 = 1'b0, en_aux1 = 1'b0, order_sel = 1'b0;
    logic [AW-1:0] word_addr;
    logic          burst_on, selected;

    int   total = 0;
    int   bad = 0;
    exp_t q[$];

    always #(CLK_T/2) clk = ~clk;

    burst_addr_gen #(.AW(AW)) i_burst_addr_gen (
        .clk(clk), .rst(rst), .addr_in(addr_in), .load_cpu(load_cpu), .load_ctl(load_ctl),
        .advance(advance), .en_main(en_main), .en_aux0(en_aux0), .en_aux1(en_aux1),
        .order_sel(order_sel), .word_addr(word_addr), .burst_on(burst_on), .selected(selected)
    );

    task automatic compare(input exp_t e);
        total++;
        if (word_addr !== e.a || burst_on !== e.act || selected !== e.sel) begin
            bad++;
            $display("FAIL %s: got addr=%h act=%b sel=%b expected addr=%h act=%b sel=%b",
                     e.req, word_addr, burst_on, selected, e.a, e.act, e.sel);
        end
    endtask

    // monitor: each item pushed at a falling edge is checked after the next rising edge
    always @(posedge clk) begin
        #(CLK_T/4);
        if (q.size() > 0) compare(q.pop_front());
    end

    task automatic drive(input logic lc, input logic lk, input logic ad,
                         input logic em, input logic e0, input logic e1, input logic ord,
                         input logic [AW-1:0] a,
                         input logic [AW-1:0] xa, input logic xact, input logic xsel,
                         input string req);
        exp_t e;
        @(negedge clk);
        load_cpu = lc; load_ctl = lk; advance = ad;
        en_main = em; en_aux0 = e0; en_aux1 = e1; order_sel = ord; addr_in = a;
        e.a = xa; e.act = xact; e.sel = xsel; e.req = req;
        q.push_back(e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        logic [AW-1:0] cur;

        repeat (3) @(posedge clk);
        @(negedge clk);
        compare('{a: '0, act: 1'b0, sel: 1'b0, req: "R1"});
        rst = 1'b0;

        // R2: processor load
        drive(1,0,0, 1,1,1, 0, 20'h12345, 20'h12345, 1, 1, "R2");

        // R6 and R8: linear order, all start values, wrap on the fourth advance
        base = 20'hABCD0;
        for (int s = 0; s < 4; s++) begin
            drive(1,0,0, 1,1,1, 0, base | s, base | s, 1, 1, "R2");
            for (int n = 1; n <= 4; n++) begin
                drive(0,0,1, 1,1,1, 0, 20'h0, base | ((s + n) % 4), 1, 1,
                      n == 4 ? "R8" : "R6");
            end
        end

        // R7 and R8: interleaved order through the controller strobe
        base = 20'h5A5A4;
        for (int s = 0; s < 4; s++) begin
            drive(0,1,0, 1,1,1, 1, base | s, base | s, 1, 1, "R4");
            for (int n = 1; n <= 4; n++) begin
                drive(0,0,1, 1,1,1, 1, 20'h0, base | (s ^ (n % 4)), 1, 1,
                      n == 4 ? "R8" : "R7");
            end
        end

        // R9: advance low holds (start 2 linear -> step to 3, then hold)
        drive(1,0,0, 1,1,1, 0, 20'h00F02, 20'h00F02, 1, 1, "R2");
        drive(0,0,1, 1,1,1, 0, 20'h0, 20'h00F03, 1, 1, "R6");
        drive(0,0,0, 1,1,1, 0, 20'h77777, 20'h00F03, 1, 1, "R9");

        // R5: auxiliary enables low without a strobe change nothing
        drive(0,0,1, 1,0,0, 0, 20'h0, 20'h00F00, 1, 1, "R5");

        // R3: masked processor strobe
        drive(1,0,0, 0,1,1, 0, 20'h11111, 20'h00F00, 1, 1, "R3");

        // R4: controller strobe with an auxiliary enable low deselects
        drive(0,1,0, 1,1,0, 0, 20'h22222, 20'h00F00, 0, 0, "R4");

        // R10: advance with no active burst
        drive(0,0,1, 1,1,1, 0, 20'h0, 20'h00F00, 0, 0, "R10");
        drive(0,0,1, 1,1,1, 1, 20'h0, 20'h00F00, 0, 0, "R10");

        // R4: processor strobe with an auxiliary enable low deselects
        drive(1,0,0, 1,1,1, 0, 20'h33330, 20'h33330, 1, 1, "R2");
        drive(1,0,0, 1,0,1, 0, 20'h44440, 20'h33330, 0, 0, "R4");

        // R11: both strobes
        drive(1,1,0, 1,1,1, 0, 20'h66661, 20'h66661, 1, 1, "R11");
        drive(1,1,0, 0,1,1, 0, 20'h99999, 20'h66661, 0, 0, "R11");

        // R12: back-to-back loads
        cur = 20'h80000;
        for (int i = 0; i < 5; i++) begin
            cur = cur + 20'h01013;
            drive(i % 2 == 0, i % 2 == 1, 1, 1,1,1, 0, cur, cur, 1, 1, "R12");
        end

        drive(0,0,0, 1,1,1, 0, 20'h0, cur, 1, 1, "R9");
        @(negedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule